// File: doc/BRIEF.md
# First-Error Capture and Logging Unit

This unit keeps the error state of a packet-processing block. Each detected error is reported as a one-cycle event that carries a type code, the offending packet's header fields, its address and its candidate data flits. Every type code has one bit in a sticky error vector. While any bit of that vector is set, the interrupt request stays high. Software clears chosen bits by writing a mask to a separate clear address.

Alongside the vector, a single capture set keeps the details of the first error: a header word with valid and overrun flags, a 38-bit address word and a 64-bit data word. Later errors only raise the overrun flag. Loss of the global clock is logged in the vector and never reaches the capture set.

Software can fake an error by loading the capture words first and then setting bits in the vector. The interrupt reacts to these bits in the same way it reacts to hardware events. The capture set is re-armed by writing a header word whose valid bit is 0. Detecting packet errors and parsing packets belong to other blocks.

Top module: `err_log_unit`

## Requirements
- R1: An event of type t with t from 0 to 10 sets vector bit t. Bit 0 is request bad command, 1 reply bad command, 2 request short, 3 reply short, 4 request long, 5 reply long, 6 request bad data, 7 reply bad data, 8 request bad address, 9 request bad invalidate and 10 global clock drop. Events of types 11 to 15 change nothing.
- R2: Reset does not change the vector. Reading the vector (register select 0) has no side effect. Bits 63:11 of the vector read as 0.
- R3: `irq` is high exactly when at least one vector bit is set. It follows the vector from the same clock edge that updates the vector.
- R4: A write to select 1 clears each vector bit whose data bit is 1. It leaves every bit whose data bit is 0 unchanged.
- R5: A write to select 0 ORs data bits [10:0] into the vector. Data bits above 10 are ignored.
- R6: If an event sets a vector bit in the same cycle that a clear write hits that bit, the bit ends up set.
- R7: An error of a type other than 10 that arrives while the valid flag is 0 does four things: it stores command, supplement, source and type, stores the event address, sets the valid flag and clears the overrun flag.
- R8: The header word at select 2 has command in [6:0], supplement in [18:8], source in [30:20], type in [35:32], overrun in [40] and valid in [44]. All other bits read as 0. The stored type equals the error's vector bit position.
- R9: An error of a type other than 10 that arrives while the valid flag is 1 sets the overrun flag. The stored header, address and data stay as they were.
- R10: A type 10 event sets only vector bit 10. The header, address and data words stay as they were.
- R11: On a first capture of type 4 to 9, the data word (select 4) loads flit 3 when `evt_vpkt` is 1 and flit 2 when it is 0. On a first capture of type 0 to 3, the data word keeps its value.
- R12: The address word (select 3) holds 38 bits in [37:0], and bits [63:38] read as 0.
- R13: Writes to select 2, 3 and 4 load the header, address and data words. A header write sets only the fields of R8, and if it carries valid = 0 it re-arms capture.
- R14: `reg_rdata` shows the register picked by `reg_addr` one cycle later. Select 1 and selects 5 to 7 read as 0. Reset clears the header, address and data words and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_vld | input | 1 | Error event strobe |
| evt_type | input | 4 | Error type, equal to its vector bit position |
| evt_cmd | input | 7 | Packet command field |
| evt_sup | input | 11 | Packet supplement field |
| evt_src | input | 11 | Packet source field |
| evt_adr | input | 38 | Packet address field |
| evt_flit2 | input | 64 | Second flit of the packet |
| evt_flit3 | input | 64 | Third flit of the packet |
| evt_vpkt | input | 1 | Packet is of the vector kind (expected data in flit 3) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets four cases:

- **Overrun.** A second error after the first must set overrun and leave the first error's fields in place. A design that re-captured on every error would overwrite the first error's fields. A design that ignored a busy capture set would never raise overrun.
- **Global clock drop.** A clock-drop event sent while capture is busy shows whether this class wrongly marks overrun or disturbs the stored words.
- **Set versus clear.** A clear write in the same cycle as a matching event would, if priority were wrong, drop the bit and the interrupt along with it.
- **Reset, flit choice and injection.** A reset pulse with bits set would empty a vector that should survive reset. Capturing the wrong flit, or updating data on a short error, shows up in the data word. Writes of all ones expose header or address bits that should read as zero.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int WORD_W = 64;
  localparam int ERR_N  = 11;
  localparam int TYPE_W = 4;
  localparam int CMD_W  = 7;
  localparam int SUP_W  = 11;
  localparam int SRC_W  = 11;
  localparam int ADR_W  = 38;
  localparam int RA_W   = 3;

  // header word field positions
  localparam int POS_SUP  = 8;
  localparam int POS_SRC  = 20;
  localparam int POS_TYPE = 32;
  localparam int POS_OVR  = 40;
  localparam int POS_VLD  = 44;

  localparam logic [TYPE_W-1:0] T_GCLK     = 4'd10;
  localparam logic [TYPE_W-1:0] T_DATA_MIN = 4'd4;

  typedef enum logic [RA_W-1:0] {
    RA_VEC = 3'd0,
    RA_CLR = 3'd1,
    RA_HDR = 3'd2,
    RA_ADR = 3'd3,
    RA_DAT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/err_vec_reg.sv
module err_vec_reg #(
  parameter int N = err_log_pkg::ERR_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] vec,
  output logic         irq
);
  logic [N-1:0] vec_q, vec_d;
  logic         irq_q;

  // contents are deliberately not reset; set sources win over clear
  always_comb begin
    vec_d = vec_q;
    if (!rst) vec_d = (vec_q & ~sw_clr) | sw_set | hw_set;
  end

  always_ff @(posedge clk) begin
    vec_q <= vec_d;
    irq_q <= |vec_d;
  end

  assign vec = vec_q;
  assign irq = irq_q;

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((hw_set & sw_clr) != '0) |=> ((vec_q & $past(hw_set & sw_clr)) == $past(hw_set & sw_clr))); // R6

  AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (rst)
    ((~vec_q & $past(vec_q) & ~$past(sw_clr)) == '0)); // R2
endmodule

// File: rtl/err_capture.sv
module err_capture
  import err_log_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int N    = ERR_N,
  parameter int TW   = TYPE_W,
  parameter int CW   = CMD_W,
  parameter int SW   = SUP_W,
  parameter int RW   = SRC_W,
  parameter int AW   = ADR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_vld,
  input  logic [TW-1:0] evt_type,
  input  logic [CW-1:0] evt_cmd,
  input  logic [SW-1:0] evt_sup,
  input  logic [RW-1:0] evt_src,
  input  logic [AW-1:0] evt_adr,
  input  logic [W-1:0]  evt_flit2,
  input  logic [W-1:0]  evt_flit3,
  input  logic          evt_vpkt,
  input  logic          hdr_we,
  input  logic          adr_we,
  input  logic          dat_we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  hdr_word,
  output logic [W-1:0]  adr_word,
  output logic [W-1:0]  dat_word
);
  localparam int APAD = W - AW;

  logic [CW-1:0] cmd_q;
  logic [SW-1:0] sup_q;
  logic [RW-1:0] src_q;
  logic [TW-1:0] typ_q;
  logic          ovr_q, vld_q;
  logic [AW-1:0] adr_q;
  logic [W-1:0]  dat_q;

  logic takes, first;
  assign takes = evt_vld && (evt_type < TW'(N)) && (evt_type != T_GCLK);
  assign first = takes && !vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; sup_q <= '0; src_q <= '0; typ_q <= '0;
      ovr_q <= 1'b0; vld_q <= 1'b0;
    end else if (hdr_we) begin
      cmd_q <= wdata[CW-1:0];
      sup_q <= wdata[POS_SUP +: SW];
      src_q <= wdata[POS_SRC +: RW];
      typ_q <= wdata[POS_TYPE +: TW];
      ovr_q <= wdata[POS_OVR];
      vld_q <= wdata[POS_VLD];
    end else if (takes) begin
      if (!vld_q) begin
        cmd_q <= evt_cmd; sup_q <= evt_sup; src_q <= evt_src; typ_q <= evt_type;
        vld_q <= 1'b1;
        ovr_q <= 1'b0;
      end else begin
        ovr_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         adr_q <= '0;
    else if (adr_we) adr_q <= wdata[AW-1:0];
    else if (first)  adr_q <= evt_adr;
  end

  always_ff @(posedge clk) begin
    if (rst)         dat_q <= '0;
    else if (dat_we) dat_q <= wdata;
    else if (first && (evt_type >= T_DATA_MIN)) dat_q <= evt_vpkt ? evt_flit3 : evt_flit2;
  end

  always_comb begin
    hdr_word = '0;
    hdr_word[CW-1:0]          = cmd_q;
    hdr_word[POS_SUP +: SW]   = sup_q;
    hdr_word[POS_SRC +: RW]   = src_q;
    hdr_word[POS_TYPE +: TW]  = typ_q;
    hdr_word[POS_OVR]         = ovr_q;
    hdr_word[POS_VLD]         = vld_q;
  end

  assign adr_word = {{APAD{1'b0}}, adr_q};
  assign dat_word = dat_q;

  AST_VALID_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
    (takes && !hdr_we) |=> vld_q); // R7

  AST_OVR_ON_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (takes && vld_q && !hdr_we) |=> ovr_q); // R9

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !hdr_we) |=> ($stable(cmd_q) && $stable(sup_q) && $stable(src_q) && $stable(typ_q))); // R9

  AST_GCLK_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (evt_vld && evt_type == T_GCLK && !hdr_we && !adr_we && !dat_we)
      |=> ($stable(hdr_word) && $stable(adr_q) && $stable(dat_q))); // R10
endmodule

// File: rtl/err_log_unit.sv
module err_log_unit
  import err_log_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int N  = ERR_N,
  parameter int TW = TYPE_W,
  parameter int CW = CMD_W,
  parameter int SW = SUP_W,
  parameter int RW = SRC_W,
  parameter int AW = ADR_W,
  parameter int SA = RA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_vld,
  input  logic [TW-1:0] evt_type,
  input  logic [CW-1:0] evt_cmd,
  input  logic [SW-1:0] evt_sup,
  input  logic [RW-1:0] evt_src,
  input  logic [AW-1:0] evt_adr,
  input  logic [W-1:0]  evt_flit2,
  input  logic [W-1:0]  evt_flit3,
  input  logic          evt_vpkt,
  input  logic          reg_we,
  input  logic [SA-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          irq
);
  localparam int VPAD = W - N;

  logic [N-1:0] hw_set, sw_set, sw_clr, vec;
  logic [W-1:0] hdr_word, adr_word, dat_word;
  logic [W-1:0] rdata_q;

  // one vector bit per legal type code
  assign hw_set = (evt_vld && (evt_type < TW'(N))) ? ({{(N-1){1'b0}}, 1'b1} << evt_type) : '0;
  assign sw_set = (reg_we && reg_addr == RA_VEC) ? reg_wdata[N-1:0] : '0;
  assign sw_clr = (reg_we && reg_addr == RA_CLR) ? reg_wdata[N-1:0] : '0;

  err_vec_reg #(.N(N)) u_vec (
    .clk(clk), .rst(rst),
    .hw_set(hw_set), .sw_set(sw_set), .sw_clr(sw_clr),
    .vec(vec), .irq(irq)
  );

  err_capture #(.W(W), .N(N), .TW(TW), .CW(CW), .SW(SW), .RW(RW), .AW(AW)) u_cap (
    .clk(clk), .rst(rst),
    .evt_vld(evt_vld), .evt_type(evt_type),
    .evt_cmd(evt_cmd), .evt_sup(evt_sup), .evt_src(evt_src), .evt_adr(evt_adr),
    .evt_flit2(evt_flit2), .evt_flit3(evt_flit3), .evt_vpkt(evt_vpkt),
    .hdr_we(reg_we && reg_addr == RA_HDR),
    .adr_we(reg_we && reg_addr == RA_ADR),
    .dat_we(reg_we && reg_addr == RA_DAT),
    .wdata(reg_wdata),
    .hdr_word(hdr_word), .adr_word(adr_word), .dat_word(dat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (reg_addr)
        RA_VEC:  rdata_q <= {{VPAD{1'b0}}, vec};
        RA_HDR:  rdata_q <= hdr_word;
        RA_ADR:  rdata_q <= adr_word;
        RA_DAT:  rdata_q <= dat_word;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;

  AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (evt_vld && (evt_type < TW'(N))) |=> irq); // R3

  AST_IRQ_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    irq |-> (vec != '0)); // R3
endmodule

// File: tb/tb_err_log_unit.sv
`timescale 1ns/1ps
module tb_err_log_unit;
  logic        clk = 1'b0, rst = 1'b1;
  logic        evt_vld = 1'b0, evt_vpkt = 1'b0, reg_we = 1'b0;
  logic [3:0]  evt_type = '0;
  logic [6:0]  evt_cmd = '0;
  logic [10:0] evt_sup = '0, evt_src = '0;
  logic [37:0] evt_adr = '0;
  logic [63:0] evt_flit2 = '0, evt_flit3 = '0, reg_wdata = '0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_rdata;
  logic        irq;

  localparam logic [63:0] F2 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] F3 = 64'hFEDC_BA98_7654_3210;

  always #2.5 clk = ~clk;

  err_log_unit dut (.*);

  int n_chk = 0, n_err = 0;
  string cur_tag = "R14";
  bit cmp_on = 1'b0;

  // behavioural reference model
  logic [10:0] m_vec = '0;
  bit          m_known = 1'b0;
  logic [6:0]  m_cmd = '0;
  logic [10:0] m_sup = '0, m_src = '0;
  logic [3:0]  m_typ = '0;
  bit          m_ovr = 1'b0, m_vld = 1'b0;
  logic [37:0] m_adr = '0;
  logic [63:0] m_dat = '0, m_rd = '0;

  function automatic logic [63:0] hw(input logic [6:0] c, input logic [10:0] s, input logic [10:0] r,
                                     input logic [3:0] t, input bit o, input bit v);
    return 64'(c) | (64'(s) << 8) | (64'(r) << 20) | (64'(t) << 32) | (64'(o) << 40) | (64'(v) << 44);
  endfunction

  always @(posedge clk) begin
    logic [10:0] hs, ss, cc;
    bit real_err, first;
    if (rst) begin
      m_rd = '0; m_vld = 0; m_ovr = 0; m_cmd = '0; m_sup = '0; m_src = '0; m_typ = '0;
      m_adr = '0; m_dat = '0;
    end else begin
      case (reg_addr)
        3'd0: m_rd = {53'b0, m_vec};
        3'd2: m_rd = hw(m_cmd, m_sup, m_src, m_typ, m_ovr, m_vld);
        3'd3: m_rd = {26'b0, m_adr};
        3'd4: m_rd = m_dat;
        default: m_rd = '0;
      endcase
      hs = (evt_vld && evt_type < 11) ? (11'd1 << evt_type) : '0;
      ss = (reg_we && reg_addr == 3'd0) ? reg_wdata[10:0] : '0;
      cc = (reg_we && reg_addr == 3'd1) ? reg_wdata[10:0] : '0;
      m_vec = (m_vec & ~cc) | ss | hs;
      if (reg_we && reg_addr == 3'd1 && reg_wdata[10:0] == 11'h7FF) m_known = 1;
      real_err = evt_vld && evt_type < 11 && evt_type != 4'd10;
      first = real_err && !m_vld;
      if (reg_we && reg_addr == 3'd3) m_adr = reg_wdata[37:0];
      else if (first) m_adr = evt_adr;
      if (reg_we && reg_addr == 3'd4) m_dat = reg_wdata;
      else if (first && evt_type >= 4) m_dat = evt_vpkt ? evt_flit3 : evt_flit2;
      if (reg_we && reg_addr == 3'd2) begin
        m_cmd = reg_wdata[6:0]; m_sup = reg_wdata[18:8]; m_src = reg_wdata[30:20];
        m_typ = reg_wdata[35:32]; m_ovr = reg_wdata[40]; m_vld = reg_wdata[44];
      end else if (first) begin
        m_cmd = evt_cmd; m_sup = evt_sup; m_src = evt_src; m_typ = evt_type;
        m_vld = 1; m_ovr = 0;
      end else if (real_err) m_ovr = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if (reg_rdata !== m_rd) begin
        n_err++;
        $display("FAIL %s: model rdata got %h expected %h", cur_tag, reg_rdata, m_rd);
      end
      if (m_known) begin
        n_chk++;
        if (irq !== (m_vec != 0)) begin
          n_err++;
          $display("FAIL R3 (%s): model irq got %b expected %b", cur_tag, irq, (m_vec != 0));
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    @(negedge clk); reg_addr = a; reg_we = 0;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic drive_evt(input logic [3:0] t, input logic [6:0] c, input logic [10:0] s,
                           input logic [10:0] r, input logic [37:0] a, input bit vp);
    evt_type = t; evt_cmd = c; evt_sup = s; evt_src = r; evt_adr = a; evt_vpkt = vp;
    evt_flit2 = F2; evt_flit3 = F3; evt_vld = 1;
  endtask

  task automatic ev(input logic [3:0] t, input logic [6:0] c, input logic [10:0] s,
                    input logic [10:0] r, input logic [37:0] a, input bit vp);
    @(negedge clk); drive_evt(t, c, s, r, a, vp);
    @(negedge clk); evt_vld = 0;
  endtask

  task automatic ev_clr(input logic [3:0] t, input logic [6:0] c, input logic [10:0] s,
                        input logic [10:0] r, input logic [37:0] a, input bit vp, input logic [63:0] m);
    @(negedge clk); drive_evt(t, c, s, r, a, vp);
    reg_addr = 3'd1; reg_wdata = m; reg_we = 1;
    @(negedge clk); evt_vld = 0; reg_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = "R14";
    rd(3'd2, v); chk("R14 header after reset", v, 64'h0);
    rd(3'd5, v); chk("R14 unmapped select", v, 64'h0);
    wr(3'd1, '1);
    rd(3'd0, v); chk("R4 vector after full clear", v, 64'h0);
    chk("R3 irq idle", {63'b0, irq}, 64'h0);
    cmp_on = 1;

    cur_tag = "R7";
    ev(4'd5, 7'h15, 11'h3A5, 11'h1C3, 38'h2A_1234_5678, 1);
    rd(3'd0, v); chk("R1 reply long sets bit 5", v, 64'h20);
    chk("R3 irq after event", {63'b0, irq}, 64'h1);
    rd(3'd2, v); chk("R8 first header", v, hw(7'h15, 11'h3A5, 11'h1C3, 4'd5, 0, 1));
    rd(3'd3, v); chk("R12 captured address", v, {26'b0, 38'h2A_1234_5678});
    rd(3'd4, v); chk("R11 long on vector packet takes flit 3", v, F3);

    cur_tag = "R9";
    ev(4'd2, 7'h01, 11'h001, 11'h002, 38'h1, 0);
    rd(3'd0, v); chk("R1 request short adds bit 2", v, 64'h24);
    rd(3'd2, v); chk("R9 overrun set, fields kept", v, hw(7'h15, 11'h3A5, 11'h1C3, 4'd5, 1, 1));
    rd(3'd3, v); chk("R9 address kept", v, {26'b0, 38'h2A_1234_5678});

    cur_tag = "R10";
    wr(3'd2, hw(7'h15, 11'h3A5, 11'h1C3, 4'd5, 0, 1));
    ev(4'd10, 7'h33, 11'h044, 11'h055, 38'h77, 1);
    rd(3'd0, v); chk("R10 clock drop sets bit 10", v, 64'h424);
    rd(3'd2, v); chk("R10 header untouched, no overrun", v, hw(7'h15, 11'h3A5, 11'h1C3, 4'd5, 0, 1));
    rd(3'd4, v); chk("R10 data untouched", v, F3);

    cur_tag = "R1";
    ev(4'd12, 7'h01, 11'h1, 11'h1, 38'h1, 0);
    rd(3'd0, v); chk("R1 type 12 ignored", v, 64'h424);
    rd(3'd2, v); chk("R1 type 12 no overrun", v, hw(7'h15, 11'h3A5, 11'h1C3, 4'd5, 0, 1));

    cur_tag = "R2";
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    rd(3'd0, v); chk("R2 vector survives reset", v, 64'h424);
    rd(3'd0, v); chk("R2 read has no side effect", v, 64'h424);
    chk("R3 irq after reset with bits set", {63'b0, irq}, 64'h1);
    rd(3'd2, v); chk("R14 header cleared by reset", v, 64'h0);

    cur_tag = "R4";
    wr(3'd1, 64'h020);
    rd(3'd0, v); chk("R4 masked clear of bit 5", v, 64'h404);
    rd(3'd1, v); chk("R14 clear select reads zero", v, 64'h0);

    cur_tag = "R6";
    ev_clr(4'd2, 7'h7F, 11'h7FF, 11'h000, 38'h3F_FFFF_FFFF, 1, 64'h004);
    rd(3'd0, v); chk("R6 set wins over clear", v, 64'h404);
    rd(3'd2, v); chk("R7 capture after re-arm", v, hw(7'h7F, 11'h7FF, 11'h000, 4'd2, 0, 1));
    rd(3'd4, v); chk("R11 short error leaves data", v, 64'h0);
    rd(3'd3, v); chk("R12 full-width address", v, {26'b0, 38'h3F_FFFF_FFFF});

    cur_tag = "R13";
    wr(3'd2, 64'h0);
    ev(4'd8, 7'h22, 11'h100, 11'h200, 38'h5, 0);
    rd(3'd2, v); chk("R8 bad address type 8", v, hw(7'h22, 11'h100, 11'h200, 4'd8, 0, 1));
    rd(3'd4, v); chk("R11 non-vector packet takes flit 2", v, F2);
    wr(3'd2, '1);
    rd(3'd2, v); chk("R13 header write keeps only fields", v, hw(7'h7F, 11'h7FF, 11'h7FF, 4'hF, 1, 1));
    wr(3'd3, '1);
    rd(3'd3, v); chk("R12 address upper bits zero", v, {26'b0, {38{1'b1}}});
    wr(3'd4, 64'hDEAD_BEEF_0BAD_F00D);
    rd(3'd4, v); chk("R13 data write", v, 64'hDEAD_BEEF_0BAD_F00D);

    cur_tag = "R5";
    wr(3'd1, '1);
    chk("R3 irq low after clearing all", {63'b0, irq}, 64'h0);
    wr(3'd0, 64'hFFFF_F000_0000_0080);
    rd(3'd0, v); chk("R5 direct set, upper bits ignored", v, 64'h080);
    chk("R5 injected bit raises irq", {63'b0, irq}, 64'h1);
    wr(3'd0, 64'h001);
    rd(3'd0, v); chk("R5 direct write ORs", v, 64'h081);
    wr(3'd1, 64'h081);
    chk("R3 irq drops when vector empty", {63'b0, irq}, 64'h0);

    @(negedge clk);
    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule